// File: doc/BRIEF.md
# I2C Target with Sparse Register Map

This block is a serial-bus target that runs entirely on a fast system clock. It synchronizes the clock and data lines of an I2C bus, finds START and STOP conditions, recognizes its own 7-bit device address, and then gives the bus controller byte access to a small register map. Only some addresses in the map hold a register, and some registers are narrower than a byte. The data line is driven as open drain: the block only ever asserts a pull-low enable and reads the resolved line back.

A controller writes by sending the device address with the write direction, then a register pointer, then any number of data bytes. Each data byte lands at the current pointer, after which the pointer moves to the next address that holds a register. To read, the controller loads the pointer with a write transaction, issues a repeated START with the read direction and clocks bytes out until it answers a byte with NACK. One read-only register keeps a two-deep history of a sampled status input, updated by a strobe from the surrounding logic.

Top module: `i2ct_target`

## Requirements
- R1: A falling SDA while SCL is high is a START and begins a new device-address byte from any state, aborting a partial byte. A rising SDA while SCL is high is a STOP and returns the block to idle.
- R2: The first byte after START is a 7-bit device address, sent MSB first, followed by a direction bit (1 = read, 0 = write). The block's address is binary 0111, then `dev_strap_i[1]`, then `dev_strap_i[0]`, then 0. On a match the block pulls SDA low for the ninth clock.
- R3: On an address mismatch the block gives no acknowledge and leaves SDA released for every following bit until the next START.
- R4: In a write, the byte after the device address loads the 8-bit register pointer. Every later byte is acknowledged, stored at the current pointer, and the pointer then advances.
- R5: A received data byte changes the register only at the rising SCL edge of its acknowledge clock. During the low phase that follows the eighth data bit, the old value is still held.
- R6: The pointer advances to the smallest allocated address above it. When there is none, it wraps to the smallest allocated address. The default map allocates addresses 0, 1, 2, 5, 6, 9 and 15 of a 16-entry space.
- R7: A read starts with a repeated START and the read bit. Bytes come out MSB first, starting at the loaded pointer and advancing by R6 after each byte. A pointer at an unallocated address returns 0x00 for that byte.
- R8: A register narrower than 8 bits stores only its low bits and returns 0 in the unused upper bits. By default address 2 is 4 bits wide, address 6 is 6 bits wide and address 9 is 2 bits wide.
- R9: Address 9 is the status history. On each clock with `sample_stb_i` high, bit 0 takes the old bit 1 and bit 1 takes `sample_in_i`. Bus writes to address 9 are acknowledged but do not change it.
- R10: A controller NACK after a read byte ends the transfer. SDA then stays released until the next START or STOP.
- R11: The block changes its SDA drive only while SCL is low. A line change takes effect at the third rising clock edge after it reaches the pin. A read byte is captured at the edge that acts on the SCL fall before its first bit, so a status capture in that same edge is not visible in the byte.
- R12: After reset SDA is released and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Resolved bus data line |
| sda_oe_o | output | 1 | Pull-low enable for the data line |
| dev_strap_i | input | 2 | Strap bits forming address bits 2 and 1 |
| sample_stb_i | input | 1 | Capture strobe for the status history |
| sample_in_i | input | 1 | Value captured into the status history |
| reg_q_o | output | REGS*8 | Contents of all register slots, slot n at bits 8n+7:8n |

## Verification
Two actions can land on the same clock edge: the capture of the status register into the transmit shifter at the start of a read byte, and a status history shift caused by the strobe. The bench fixes a known history and then drops SCL to end the address acknowledge. It places a single strobe at each edge from the first to the fifth after that drop, with a new sample that differs from the old one. The returned byte must show the shifted history only when the strobe comes before the third edge, and the old history when it lands on that edge or later.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_PTR, ST_PTRACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } state_t;

  localparam int MAP_REGS = 16;
  localparam logic [MAP_REGS-1:0] MAP_ALLOC = 16'h8267;
  localparam logic [MAP_REGS-1:0][7:0] MAP_MASK =
    128'hFFFF_FFFF_FFFF_03FF_FF3F_FFFF_FF0F_FFFF;
  localparam int MAP_STAT = 9;
  localparam logic [3:0] DEV_CODE = 4'b0111;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  // bus lines idle high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/i2ct_ptr_step.sv
module i2ct_ptr_step #(
  parameter int                REGS  = 16,
  parameter logic [REGS-1:0]   ALLOC = '1
) (
  input  logic [7:0] ptr_i,
  output logic [7:0] nxt_o
);
  // smallest allocated address above ptr, else smallest allocated address
  always_comb begin
    nxt_o = '0;
    for (int i = REGS - 1; i >= 0; i--) begin
      if (ALLOC[i]) nxt_o = 8'(i);
    end
    for (int i = REGS - 1; i >= 0; i--) begin
      if (ALLOC[i] && (i > int'(ptr_i))) nxt_o = 8'(i);
    end
  end
endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
  parameter int                    REGS  = 16,
  parameter logic [REGS-1:0]       ALLOC = '1,
  parameter logic [REGS-1:0][7:0]  MASK  = '1,
  parameter int                    STAT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              smp_stb_i,
  input  logic              smp_in_i,
  output logic [7:0]        rd_data_o,
  output logic [REGS*8-1:0] regs_o
);
  localparam int PW = (REGS > 1) ? $clog2(REGS) : 1;

  logic       hit;
  logic [7:0] slot [REGS];

  assign hit = ({24'b0, addr_i} < REGS);

  for (genvar i = 0; i < REGS; i++) begin : g_slot
    if (!ALLOC[i]) begin : g_hole
      assign slot[i] = '0;
    end else if (i == STAT) begin : g_hist
      logic [1:0] hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hist_q <= '0;
        else if (smp_stb_i) hist_q <= {smp_in_i, hist_q[1]};
      end
      assign slot[i] = {6'b0, hist_q};
    end else begin : g_data
      logic       we;
      logic [7:0] data_q;
      assign we = wr_en_i && hit && (addr_i[PW-1:0] == PW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  data_q <= '0;
        else if (we) data_q <= wr_data_i & MASK[i];
      end
      assign slot[i] = data_q;
    end
    assign regs_o[i*8 +: 8] = slot[i];
  end

  assign rd_data_o = hit ? slot[addr_i[PW-1:0]] : 8'h00;
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int                    REGS  = MAP_REGS,
  parameter logic [REGS-1:0]       ALLOC = MAP_ALLOC,
  parameter logic [REGS-1:0][7:0]  MASK  = MAP_MASK,
  parameter int                    STAT  = MAP_STAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        dev_strap_i,
  input  logic              sample_stb_i,
  input  logic              sample_in_i,
  output logic [REGS*8-1:0] reg_q_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sq;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_q = rst_sq[1];

  logic [1:0] lvl, rise, fall;
  i2ct_sync #(.W(2)) sync_i (
    .clk(clk), .rst_n(rst_q), .pin_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign bus_start = fall[1] & scl_lvl;
  assign bus_stop  = rise[1] & scl_lvl;

  state_t     state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d, ptr_q, ptr_d;
  logic       rw_q, rw_d, oe_q, oe_d, mack_q, mack_d;
  logic       wr_en;
  logic [7:0] rd_data, ptr_nxt;
  logic [6:0] dev_id;

  assign dev_id = {DEV_CODE, dev_strap_i, 1'b0};

  i2ct_ptr_step #(.REGS(REGS), .ALLOC(ALLOC)) step_i (
    .ptr_i(ptr_q), .nxt_o(ptr_nxt)
  );

  i2ct_regfile #(.REGS(REGS), .ALLOC(ALLOC), .MASK(MASK), .STAT(STAT)) rf_i (
    .clk(clk), .rst_n(rst_q), .wr_en_i(wr_en), .addr_i(ptr_q),
    .wr_data_i(sh_q), .smp_stb_i(sample_stb_i), .smp_in_i(sample_in_i),
    .rd_data_o(rd_data), .regs_o(reg_q_o)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (bus_start) begin
      state_d = ST_DEVADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEVADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = '0;
            if (state_q == ST_DEVADDR) begin
              if (sh_q[7:1] == dev_id) begin
                rw_d    = sh_q[0];
                state_d = ST_DEVACK;
                oe_d    = 1'b1;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d = (state_q == ST_PTR) ? ST_PTRACK : ST_WACK;
              oe_d    = 1'b1;
            end
          end
        end
        ST_DEVACK, ST_PTRACK, ST_WACK: begin
          if (scl_rise) begin
            if (state_q == ST_PTRACK) ptr_d = sh_q;
            if (state_q == ST_WACK) begin
              wr_en = 1'b1;
              ptr_d = ptr_nxt;
            end
          end else if (scl_fall) begin
            oe_d = 1'b0;
            if (state_q == ST_DEVACK && rw_q) begin
              tx_d    = rd_data;
              ptr_d   = ptr_nxt;
              oe_d    = ~rd_data[7];
              state_d = ST_RDATA;
            end else begin
              state_d = (state_q == ST_DEVACK) ? ST_PTR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d    = 1'b0;
              bit_d   = '0;
              state_d = ST_RACK;
            end else begin
              oe_d = ~tx_q[3'd7 - bit_q[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d    = rd_data;
              ptr_d   = ptr_nxt;
              oe_d    = ~rd_data[7];
              state_d = ST_RDATA;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2ct_target_chk.sv
module i2ct_target_chk
  import i2ct_pkg::*;
#(
  parameter int                    REGS  = MAP_REGS,
  parameter logic [REGS-1:0]       ALLOC = MAP_ALLOC,
  parameter logic [REGS-1:0][7:0]  MASK  = MAP_MASK,
  parameter int                    STAT  = MAP_STAT
) (
  input logic              clk,
  input logic              rst_n,
  input state_t            state,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              wr_en,
  input logic [7:0]        ptr,
  input logic [7:0]        rd_data,
  input logic [REGS*8-1:0] regs,
  input logic              smp_stb,
  input logic              smp_in
);
  localparam int PW = (REGS > 1) ? $clog2(REGS) : 1;
  localparam logic [REGS*8-1:0] STAT_BITS = {{(REGS*8-8){1'b0}}, 8'hFF} << (8*STAT);

  logic [1:0] hist;
  logic       ptr_ok;
  logic [7:0] pad_mask;
  assign hist     = regs[STAT*8 +: 2];
  assign ptr_ok   = ({24'b0, ptr} < REGS);
  assign pad_mask = ptr_ok ? ~MASK[ptr[PW-1:0]] : 8'hFF;

  // R11: drive edits only while the synchronized clock line is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

  // R3: idle block never pulls the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5: stored data moves only after a commit
  a_r5_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(regs) ^ regs) & ~STAT_BITS) != '0) |-> $past(wr_en));

  // R6: an advanced pointer lands on an allocated address
  a_r6_ptr_allocated: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && ($past(state) != ST_PTRACK)) |-> (ptr_ok && ALLOC[ptr[PW-1:0]]));

  // R8: unused upper bits read zero
  a_r8_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & pad_mask) == 8'h00);

  // R9: history shift on strobe
  a_r9_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb) |-> (hist == {$past(smp_in), $past(hist[1])}));
endmodule

bind i2ct_target i2ct_target_chk #(
  .REGS(REGS), .ALLOC(ALLOC), .MASK(MASK), .STAT(STAT)
) chk_i (
  .clk(clk), .rst_n(rst_q), .state(state_q), .sda_oe(sda_oe_o),
  .scl_lvl(scl_lvl), .wr_en(wr_en), .ptr(ptr_q), .rd_data(rd_data),
  .regs(reg_q_o), .smp_stb(sample_stb_i), .smp_in(sample_in_i)
);

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb_top;
  localparam int H = 8;
  localparam logic [15:0] ALLOC = 16'h8267;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, stb = 1'b0, smp = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [127:0] regq;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  logic [7:0] model [16];
  logic [1:0] hist_m = 2'b00;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2ct_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_strap_i(strap), .sample_stb_i(stb),
    .sample_in_i(smp), .reg_q_o(regq)
  );

  function automatic logic [7:0] wmask(input int a);
    return (a == 2) ? 8'h0F : (a == 6) ? 8'h3F : (a == 9) ? 8'h03 : 8'hFF;
  endfunction

  function automatic int nxt(input int p);
    int r = -1;
    for (int i = 15; i >= 0; i--) if (ALLOC[i] && i > p) r = i;
    if (r < 0) for (int i = 15; i >= 0; i--) if (ALLOC[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] rd_model(input int p);
    if (p > 15 || !ALLOC[p]) return 8'h00;
    if (p == 9) return {6'b0, hist_m};
    return model[p];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_clk(H); scl_m = 1'b1; wait_clk(H); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
    b = sda_line; wait_clk(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H); scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H); scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~ack);
  endtask

  task automatic strobe(input logic v);
    @(negedge clk); stb = 1'b1; smp = v;
    @(negedge clk); stb = 1'b0;
    hist_m = {v, hist_m[1]};
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack, b;
    logic [7:0] d;
    logic [7:0] dev;
    int p;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R12: reset state
    chk("R12 oe", int'(sda_oe), 0);
    chk("R12 regs", int'(regq == '0), 1);

    // R2 / R3: address match over every strap and candidate
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int a = 0; a < 5; a++) begin
        dev = (a == 4) ? {4'b0101, 2'(s), 1'b0, 1'b0} : {4'b0111, 2'(a), 1'b0, 1'b0};
        bus_start();
        send_byte(dev, ack);
        chk("R2 addr ack", int'(ack), int'(a == s));
        if (a != s) begin
          send_byte(8'h00, ack);
          chk("R3 ignored after mismatch", int'(ack), 0);
        end
        bus_stop();
      end
    end
    strap = 2'b10;
    dev = {4'b0111, 2'b10, 1'b0, 1'b0};

    // R4 / R6 / R8 / R9: sequential write with wrap and skipping
    bus_start();
    send_byte(dev, ack);
    send_byte(8'h00, ack);
    chk("R4 ptr ack", int'(ack), 1);
    p = 0;
    for (int k = 0; k < 9; k++) begin
      d = 8'hA5 ^ 8'(k * 37);
      send_byte(d, ack);
      chk("R4 data ack", int'(ack), 1);
      if (p != 9) model[p] = d & wmask(p);
      p = nxt(p);
    end
    bus_stop();
    for (int a = 0; a < 16; a++) chk("R6 R8 R9 slot", int'(regq[a*8 +: 8]), int'(rd_model(a)));

    // R7: read from an unallocated pointer, skipping holes
    bus_start(); send_byte(dev, ack); send_byte(8'h03, ack);
    bus_start(); send_byte(dev | 8'h01, ack);
    chk("R7 read addr ack", int'(ack), 1);
    p = 3;
    for (int k = 0; k < 8; k++) begin
      recv_byte(k != 7, d);
      chk("R7 R8 read byte", int'(d), int'(rd_model(p)));
      p = nxt(p);
    end
    // R10: after NACK the line stays released
    for (int k = 0; k < 9; k++) begin
      bit_in(b);
      chk("R10 released after nack", int'(b), 1);
    end
    bus_stop();

    // R5: commit at the acknowledge rising edge
    bus_start(); send_byte(dev, ack); send_byte(8'h05, ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i] | 1'b0 ? 1'b0 : 1'b0);
    sda_m = 1'b1; wait_clk(H);
    chk("R5 old value held", int'(regq[5*8 +: 8]), int'(model[5]));
    scl_m = 1'b1; wait_clk(H/2);
    chk("R5 ack driven", int'(sda_line), 0);
    chk("R5 committed", int'(regq[5*8 +: 8]), 0);
    model[5] = 8'h00;
    wait_clk(H/2); scl_m = 1'b0;
    bus_stop();

    // R1: repeated START aborts a partial data byte
    bus_start(); send_byte(dev, ack); send_byte(8'h00, ack);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    bus_start(); send_byte(dev, ack);
    chk("R1 restart ack", int'(ack), 1);
    send_byte(8'h01, ack); send_byte(8'h77, ack);
    bus_stop();
    model[1] = 8'h77;
    chk("R1 partial byte dropped", int'(regq[0 +: 8]), int'(model[0]));
    chk("R1 write after restart", int'(regq[8 +: 8]), 8'h77);

    // R9: status history and ignored bus write
    strobe(1'b1);
    chk("R9 hist a", int'(regq[72 +: 8]), int'({6'b0, hist_m}));
    strobe(1'b0);
    chk("R9 hist b", int'(regq[72 +: 8]), int'({6'b0, hist_m}));
    strobe(1'b1);
    chk("R9 hist c", int'(regq[72 +: 8]), int'({6'b0, hist_m}));
    bus_start(); send_byte(dev, ack); send_byte(8'h09, ack); send_byte(8'hFF, ack);
    chk("R9 write acked", int'(ack), 1);
    bus_stop();
    chk("R9 write ignored", int'(regq[72 +: 8]), int'({6'b0, hist_m}));

    // R11: status capture in the same edge as the read byte load
    for (int k = 1; k <= 5; k++) begin
      strobe(1'b1); strobe(1'b0);
      bus_start(); send_byte(dev, ack); send_byte(8'h09, ack);
      bus_start();
      for (int i = 7; i >= 0; i--) bit_out(dev[i] | (i == 0));
      sda_m = 1'b1; wait_clk(H); scl_m = 1'b1; wait_clk(H);
      scl_m = 1'b0;
      wait_clk(k - 1);
      stb = 1'b1; smp = 1'b1;
      @(negedge clk); stb = 1'b0;
      wait_clk(H - k);
      recv_byte(1'b0, d);
      chk("R11 capture order", int'(d), (k < 3) ? 8'h02 : 8'h01);
      hist_m = 2'b10;
      bus_stop();
    end

    finish_run();
  end
endmodule